// File: doc/BRIEF.md
# Virtual Address Translation Dispatcher

This block converts one memory request per cycle from a virtual address into a physical address, or into a fault code. Each request carries a 64-bit virtual address, a flag that marks the address as already physical, a read/write indicator, the current privilege mode, a two-bit superpage control field and an address space number. The block sends the request down exactly one of three paths, in a fixed priority order:

- **Pass-through:** a request flagged as physical passes through unchanged.
- **Superpage:** a request that meets the superpage condition is mapped directly, and only in kernel mode.
- **Table:** any other request has its address checked for correct form and is then looked up in a small, fully associative translation table, matched on page number and address space number.

Every path that succeeds has its physical address checked against the implemented 40-bit range. The table path also advances read/write access and hit counters.

Requests enter on a valid/ready handshake. Results leave from a single output register on a valid/ready handshake. A new request is accepted whenever that register is empty, or is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the result holds and no request is taken. With `rsp_ready` held high, each result is a one-cycle `rsp_valid` strobe, one cycle after acceptance. The table is loaded through a plain write port.

Top module: `xlat_dispatch`

## Requirements
- R1: Path priority is fixed: the physical flag first, then the superpage condition, then the table lookup.
- R2: With `req_phys` set, the physical address is the virtual address unchanged. No form check, no lookup and no counter update takes place.
- R3: The superpage condition is `req_spctl[1]`=1 and `req_va[42:41]`=2'b10. In kernel mode the result is `req_va[39:0]` with fault code 0, and the form of bits 63:43 is not checked.
- R4: A superpage request in user mode (`req_user`=1) returns fault code 1 (access violation) with `rsp_pa`=0. Its status has the access bit set, bad-VA clear, and the write bit equal to `req_write`.
- R5: On the table path, an address whose bits 63:43 are not all equal to bit 42 returns fault code 2. Its status has the access and bad-VA bits set, plus the write bit for writes. Status encoding: `rsp_stat` bit 2 = write, bit 1 = bad VA, bit 0 = access violation.
- R6: The table matches page number `req_va[42:13]` together with `req_asn`. A hit yields `{pfn, req_va[12:0]}`. A miss yields fault code 2, with status carrying only the write bit.
- R7: After the pass-through or table path, any address bit at or above bit 40 yields fault code 3 (machine check). Every faulting result carries `rsp_pa`=0.
- R8: Only table-path requests advance the read or write access counter. Only table hits advance the read or write hit counter, including hits that are then machine-checked.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the result stays stable.
- R10: A table write at a clock edge takes effect for lookups after that edge. A lookup in the same cycle sees the old contents. Reset clears every entry.
- R11: During and right after reset, `rsp_valid` is 0, `req_ready` is 1 and all four counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_va | input | 64 | Virtual address |
| req_phys | input | 1 | Address is already physical |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_spctl | input | 2 | Superpage control, bit 1 enables mapping |
| req_asn | input | 8 | Address space number |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | 3 | Table entry to write |
| tw_vpn | input | 30 | Page number for the entry |
| tw_asn | input | 8 | Address space number for the entry |
| tw_pfn | input | 32 | Frame number for the entry |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 40 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 access violation, 2 translation fault, 3 machine check |
| rsp_stat | output | 3 | Fault status {write, bad VA, access violation} |
| cnt_rd_acc | output | 16 | Table-path read requests |
| cnt_wr_acc | output | 16 | Table-path write requests |
| cnt_rd_hit | output | 16 | Table-path read hits |
| cnt_wr_hit | output | 16 | Table-path write hits |

## Verification
The bench goes after the overlaps between paths:

- **Physical flag with superpage fields also set.** A design with the priority reversed would return a masked address instead of a machine check.
- **Superpage address with malformed upper bits.** A design that checks the form first would report a bad address.
- **Superpage fields with `req_spctl[1]` clear or bits 42:41 = 11.** These must fall through to the table path.
- **Table hit whose frame exceeds 40 bits.** This must still count as a hit and still be machine-checked. A wrong design would either drop the hit count or pass the wide address through.

It also stalls the output to prove that results are held, writes an entry in the same cycle as a lookup to prove old-contents ordering, and resets mid-run to prove that the table and counters clear.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ACV  = 2'd1,
    FLT_XLAT = 2'd2,
    FLT_MCHK = 2'd3
  } flt_e;

  typedef struct packed {
    logic wr;
    logic bad_va;
    logic acv;
  } stat_t;
endpackage

// File: rtl/xlat_va_check.sv
module xlat_va_check #(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 43,
  parameter int PAGE_BITS = 13
) (
  input  logic [VA_W-1:0]              va,
  output logic                         well_formed,
  output logic                         super_rgn,
  output logic [VA_IMPL-1:PAGE_BITS]   vpn
);
  // upper bits must all copy the top implemented bit
  logic [VA_W-VA_IMPL:0] ext;
  assign ext         = va[VA_W-1:VA_IMPL-1];
  assign well_formed = (&ext) | ~(|ext);
  assign super_rgn   = (va[VA_IMPL-1:VA_IMPL-2] == 2'b10);
  assign vpn         = va[VA_IMPL-1:PAGE_BITS];
endmodule

// File: rtl/xlat_table.sv
module xlat_table #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8,
  parameter int PFN_W   = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [ASN_W-1:0] wr_asn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn
);
  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_vpn [ENTRIES];
  logic [ASN_W-1:0]   tag_asn [ENTRIES];
  logic [PFN_W-1:0]   frame   [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[e]     <= 1'b0;
        tag_vpn[e] <= '0;
        tag_asn[e] <= '0;
        frame[e]   <= '0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        vld[e]     <= 1'b1;
        tag_vpn[e] <= wr_vpn;
        tag_asn[e] <= wr_asn;
        frame[e]   <= wr_pfn;
      end
    end
    assign match[e] = vld[e] && tag_vpn[e] == lk_vpn && tag_asn[e] == lk_asn;
  end

  // lowest matching index wins
  always_comb begin
    lk_pfn = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (match[e]) lk_pfn = frame[e];
  end
  assign lk_hit = |match;

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(wr_idx)]);
endmodule

// File: rtl/xlat_stats.sv
module xlat_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_tick,
  input  logic             hit_tick,
  input  logic             is_wr,
  output logic [CNT_W-1:0] rd_acc,
  output logic [CNT_W-1:0] wr_acc,
  output logic [CNT_W-1:0] rd_hit,
  output logic [CNT_W-1:0] wr_hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_acc <= '0;
      wr_acc <= '0;
      rd_hit <= '0;
      wr_hit <= '0;
    end else begin
      if (acc_tick &&  is_wr) wr_acc <= wr_acc + 1'b1;
      if (acc_tick && !is_wr) rd_acc <= rd_acc + 1'b1;
      if (hit_tick &&  is_wr) wr_hit <= wr_hit + 1'b1;
      if (hit_tick && !is_wr) rd_hit <= rd_hit + 1'b1;
    end
  end

  p_rd_hit_needs_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_hit) |-> !$stable(rd_acc));
  p_wr_hit_needs_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_hit) |-> !$stable(wr_acc));
endmodule

// File: rtl/xlat_dispatch.sv
module xlat_dispatch #(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 43,
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 13,
  parameter int PFN_W     = 32,
  parameter int ASN_W     = 8,
  parameter int ENTRIES   = 8,
  parameter int CNT_W     = 16,
  localparam int VPN_W    = VA_IMPL - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_phys,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [1:0]       req_spctl,
  input  logic [ASN_W-1:0] req_asn,
  input  logic             tw_en,
  input  logic [IDX_W-1:0] tw_idx,
  input  logic [VPN_W-1:0] tw_vpn,
  input  logic [ASN_W-1:0] tw_asn,
  input  logic [PFN_W-1:0] tw_pfn,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_fault,
  output logic [2:0]       rsp_stat,
  output logic [CNT_W-1:0] cnt_rd_acc,
  output logic [CNT_W-1:0] cnt_wr_acc,
  output logic [CNT_W-1:0] cnt_rd_hit,
  output logic [CNT_W-1:0] cnt_wr_hit
);
  import xlat_pkg::*;

  localparam int RAW_W = PFN_W + PAGE_BITS;

  logic              va_ok, va_super;
  logic [VPN_W-1:0]  va_vpn;
  logic              tbl_hit;
  logic [PFN_W-1:0]  tbl_pfn;
  logic [RAW_W-1:0]  tbl_raw;
  logic              accept;

  xlat_va_check #(.VA_W(VA_W), .VA_IMPL(VA_IMPL), .PAGE_BITS(PAGE_BITS)) u_chk (
    .va(req_va), .well_formed(va_ok), .super_rgn(va_super), .vpn(va_vpn));

  xlat_table #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PFN_W(PFN_W),
               .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tw_en), .wr_idx(tw_idx), .wr_vpn(tw_vpn), .wr_asn(tw_asn), .wr_pfn(tw_pfn),
    .lk_vpn(va_vpn), .lk_asn(req_asn), .lk_hit(tbl_hit), .lk_pfn(tbl_pfn));

  assign tbl_raw   = {tbl_pfn, req_va[PAGE_BITS-1:0]};
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  flt_e            nx_fault;
  stat_t           nx_stat;
  logic [PA_W-1:0] nx_pa;
  logic            on_tbl;

  // priority: physical flag, superpage, table
  always_comb begin
    nx_fault = FLT_NONE;
    nx_stat  = '0;
    nx_pa    = '0;
    on_tbl   = 1'b0;
    if (req_phys) begin
      if ((req_va >> PA_W) != '0) nx_fault = FLT_MCHK;
      else                        nx_pa    = req_va[PA_W-1:0];
    end else if (req_spctl[1] && va_super) begin
      if (req_user) begin
        nx_fault = FLT_ACV;
        nx_stat  = '{wr: req_write, bad_va: 1'b0, acv: 1'b1};
      end else begin
        nx_pa = req_va[PA_W-1:0];
      end
    end else begin
      on_tbl = 1'b1;
      if (!va_ok) begin
        nx_fault = FLT_XLAT;
        nx_stat  = '{wr: req_write, bad_va: 1'b1, acv: 1'b1};
      end else if (!tbl_hit) begin
        nx_fault = FLT_XLAT;
        nx_stat  = '{wr: req_write, bad_va: 1'b0, acv: 1'b0};
      end else if ((tbl_raw >> PA_W) != '0) begin
        nx_fault = FLT_MCHK;
      end else begin
        nx_pa = tbl_raw[PA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= '0;
      rsp_stat  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_pa    <= nx_pa;
      rsp_fault <= nx_fault;
      rsp_stat  <= nx_stat;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  xlat_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .acc_tick(accept && on_tbl),
    .hit_tick(accept && on_tbl && va_ok && tbl_hit),
    .is_wr(req_write),
    .rd_acc(cnt_rd_acc), .wr_acc(cnt_wr_acc),
    .rd_hit(cnt_rd_hit), .wr_hit(cnt_wr_hit));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
                                && $stable(rsp_stat));

  p_phys_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_phys && ((req_va >> PA_W) == '0)
    |=> rsp_valid && rsp_fault == 2'd0 && rsp_pa == $past(req_va[PA_W-1:0]));

  p_user_super_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_phys && req_spctl[1] && req_va[VA_IMPL-1:VA_IMPL-2] == 2'b10 && req_user
    |=> rsp_fault == 2'd1 && rsp_stat[0] && rsp_pa == '0);

  p_fault_zero_pa_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_pa == '0);
endmodule

// File: tb/sim_xlat_dispatch.sv
`timescale 1ns/1ps
module sim_xlat_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_va = '0;
  logic        req_phys = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [1:0]  req_spctl = '0;
  logic [7:0]  req_asn = '0;
  logic        tw_en = 1'b0;
  logic [2:0]  tw_idx = '0;
  logic [29:0] tw_vpn = '0;
  logic [7:0]  tw_asn = '0;
  logic [31:0] tw_pfn = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [39:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic [2:0]  rsp_stat;
  logic [15:0] cnt_rd_acc, cnt_wr_acc, cnt_rd_hit, cnt_wr_hit;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  xlat_dispatch u0 (.*);

  typedef struct packed {
    logic [63:0] va;
    logic        phys, wr, user;
    logic [1:0]  sp;
    logic [7:0]  asn;
    logic [1:0]  fault;
    logic [39:0] pa;
    logic [2:0]  stat;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_0000_1234_5678, 1'b1, 1'b0, 1'b0, 2'b00, 8'd5, 2'd0, 40'h00_1234_5678, 3'b000, 8'd2},  // R2
    '{64'h0000_0100_0000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 8'd5, 2'd3, 40'h0,            3'b000, 8'd7},  // R7
    '{64'h0000_0400_0000_1000, 1'b1, 1'b0, 1'b0, 2'b10, 8'd5, 2'd3, 40'h0,            3'b000, 8'd1},  // R1
    '{64'h0000_0400_0012_3456, 1'b0, 1'b0, 1'b0, 2'b10, 8'd5, 2'd0, 40'h00_0012_3456, 3'b000, 8'd3},  // R3
    '{64'h0000_0400_0012_3456, 1'b0, 1'b1, 1'b1, 2'b10, 8'd5, 2'd1, 40'h0,            3'b101, 8'd4},  // R4
    '{64'h0000_0400_0012_3456, 1'b0, 1'b0, 1'b0, 2'b01, 8'd5, 2'd2, 40'h0,            3'b011, 8'd3},  // R3 R5
    '{64'hFFFF_FE00_0000_0000, 1'b0, 1'b0, 1'b0, 2'b10, 8'd5, 2'd2, 40'h0,            3'b000, 8'd6},  // R6
    '{64'h0000_0000_2468_AABC, 1'b0, 1'b0, 1'b0, 2'b00, 8'd5, 2'd0, 40'h00_0157_8ABC, 3'b000, 8'd6},  // R6
    '{64'h0000_0000_2468_AABC, 1'b0, 1'b1, 1'b0, 2'b00, 8'd7, 2'd0, 40'h00_01BD_EABC, 3'b000, 8'd6},  // R6
    '{64'h0000_0000_2468_AABC, 1'b0, 1'b1, 1'b0, 2'b00, 8'd9, 2'd2, 40'h0,            3'b100, 8'd6},  // R6
    '{64'hFFFF_FFFF_FFFF_E123, 1'b0, 1'b0, 1'b0, 2'b00, 8'd5, 2'd0, 40'h00_0000_2123, 3'b000, 8'd6},  // R6
    '{64'h0000_0800_0000_0000, 1'b0, 1'b1, 1'b0, 2'b00, 8'd5, 2'd2, 40'h0,            3'b111, 8'd5},  // R5
    '{64'h0000_0000_0020_0000, 1'b0, 1'b0, 1'b0, 2'b00, 8'd5, 2'd3, 40'h0,            3'b000, 8'd7}   // R7
  };

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [29:0] vpn, input logic [7:0] asn,
                      input logic [31:0] pfn);
    @(negedge clk);
    tw_en = 1'b1; tw_idx = idx; tw_vpn = vpn; tw_asn = asn; tw_pfn = pfn;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    req_va = v.va; req_phys = v.phys; req_write = v.wr; req_user = v.user;
    req_spctl = v.sp; req_asn = v.asn; req_valid = 1'b1;
  endtask

  task automatic one_req(input vec_t v);
    @(negedge clk);
    drive(v);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] pack_rsp(logic v, logic [1:0] f, logic [2:0] s, logic [39:0] p);
    return {18'd0, v, f, s, p};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!rsp_valid && req_ready, "R11", {62'd0, rsp_valid, req_ready}, 64'd1);
    check(cnt_rd_acc == 0 && cnt_wr_acc == 0 && cnt_rd_hit == 0 && cnt_wr_hit == 0, "R11",
          {cnt_rd_acc, cnt_wr_acc, cnt_rd_hit, cnt_wr_hit}, 64'd0);
    rst_n = 1'b1;

    load(3'd0, 30'h0001_2345, 8'd5, 32'h0000_0ABC);
    load(3'd1, 30'h3FFF_FFFF, 8'd5, 32'h0000_0001);
    load(3'd2, 30'h0000_0100, 8'd5, 32'h8000_0000);
    load(3'd3, 30'h0001_2345, 8'd7, 32'h0000_0DEF);

    for (int i = 0; i < NV; i++) begin
      one_req(VEC[i]);
      check(rsp_valid && rsp_fault == VEC[i].fault && rsp_pa == VEC[i].pa
            && rsp_stat == VEC[i].stat, $sformatf("R%0d vec%0d", VEC[i].rq, i),
            pack_rsp(rsp_valid, rsp_fault, rsp_stat, rsp_pa),
            pack_rsp(1'b1, VEC[i].fault, VEC[i].stat, VEC[i].pa));
    end
    @(negedge clk);
    check(!rsp_valid, "R9 strobe", {63'd0, rsp_valid}, 64'd0);

    // R8 counters: table-path reads 5, writes 3, read hits 3, write hits 1
    check(cnt_rd_acc == 16'd5, "R8 rd_acc", 64'(cnt_rd_acc), 64'd5);
    check(cnt_wr_acc == 16'd3, "R8 wr_acc", 64'(cnt_wr_acc), 64'd3);
    check(cnt_rd_hit == 16'd3, "R8 rd_hit", 64'(cnt_rd_hit), 64'd3);
    check(cnt_wr_hit == 16'd1, "R8 wr_hit", 64'(cnt_wr_hit), 64'd1);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(VEC[7]);
    @(negedge clk);
    v = VEC[0];
    drive(v);
    repeat (2) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && rsp_pa == 40'h00_0157_8ABC, "R9 hold",
            pack_rsp(rsp_valid, {1'b0, req_ready}, 3'd0, rsp_pa),
            pack_rsp(1'b1, 2'd0, 3'd0, 40'h00_0157_8ABC));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_pa == 40'h00_1234_5678, "R9 drain", 64'(rsp_pa), 64'h12345678);

    // R10 same-cycle write then lookup
    @(negedge clk);
    tw_en = 1'b1; tw_idx = 3'd4; tw_vpn = 30'h55; tw_asn = 8'd5; tw_pfn = 32'h77;
    v = '{64'h0000_0000_000A_A000, 1'b0, 1'b0, 1'b0, 2'b00, 8'd5, 2'd0, 40'h0, 3'b000, 8'd10};
    drive(v);
    @(negedge clk);
    tw_en = 1'b0; req_valid = 1'b0;
    check(rsp_fault == 2'd2, "R10 old contents", 64'(rsp_fault), 64'd2);
    one_req(v);
    check(rsp_fault == 2'd0 && rsp_pa == 40'hE_E000, "R10 new entry", 64'(rsp_pa), 64'hEE000);

    // R11/R10 reset clears counters and table
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!rsp_valid && req_ready && cnt_rd_acc == 0 && cnt_rd_hit == 0, "R11 mid reset",
          {cnt_rd_acc, cnt_rd_hit, 30'd0, rsp_valid, req_ready}, 64'd1);
    rst_n = 1'b1;
    one_req(v);
    check(rsp_fault == 2'd2, "R10 reset clears", 64'(rsp_fault), 64'd2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule